// File: doc/BRIEF.md
# Triangular-Window Averaging Filter

This block smooths a stream of signed 14-bit sensor samples. It passes the stream through two identical boxcar (moving-average) stages in series. Two equal rectangular windows convolved together give a triangular weighting. The combined frequency response is therefore the square of one moving-average response. Each stage keeps a running sum and a delay line. Each stage divides by its window length with an arithmetic right shift.

The window length is N = 2^M. M comes from a 4-bit exponent input and is limited to 7, which gives at most 128 taps. A 3-bit range code can raise M to a minimum value: narrower measurement ranges need more averaging. Any change of the effective exponent or of the range code flushes both stages. After a flush, the output stays quiet until the windows have refilled. An exponent of zero turns the block into a one-cycle registered pass-through.

Top module: `tri_avg_filter`

## Requirements
- R1: With effective exponent M ≥ 1 and N = 2^M, each output is a second boxcar average of first-stage averages. Each first-stage value is floor(sum of the last N accepted samples / N). The output is floor(sum of the last N first-stage values / N). Both divisions are arithmetic right shifts and round toward minus infinity.
- R2: An exponent input above 7 is treated as 7, so the window is at most 128 taps.
- R3: The range code sets a floor on M:
  - 3'b010 raises M to at least 2.
  - 3'b001 raises M to at least 4.
  - 3'b100 and all other codes set no floor.
- R4: For M ≥ 1, the output for a sample appears on the second rising edge after the edge that accepts that sample.
- R5: After a flush, the first valid output follows the (2N−1)-th accepted sample. Each later accepted sample then produces exactly one output.
- R6: The block flushes in any cycle where the effective exponent or the range code differs from the value held from the previous cycle. A flush clears both stages. A sample presented in the flush cycle is discarded. out_vld is low in the cycle after a flush.
- R7: With M = 0, out_data equals in_data one cycle after each valid sample, and out_vld is high for that cycle only.
- R8: While rst is high, out_vld and out_data are zero. After reset, the held configuration is M = 2 with the widest range (3'b100).
- R9: Cycles with in_vld low do not advance either stage. The output depends only on the sequence of accepted samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input sample strobe |
| in_data | input | 14 | Input sample, two's complement |
| tap_exp | input | 4 | Requested window exponent M |
| range_sel | input | 3 | Range code that sets the exponent floor |
| out_vld | output | 1 | Output sample strobe |
| out_data | output | 14 | Filtered sample, two's complement |

## Verification
The assertions take four things for granted:
- tap_exp and range_sel hold steady while a stream runs, and move only between streams.
- A reconfiguration flushes the filter.
- Each stage sees its running sum bounded by N times the sample extremes.
- Valid outputs only ever follow valid inputs.

The stimulus respects these assumptions. The bench changes the configuration only while in_vld is low and then idles, with one exception. One deliberate case presents a sample in the same cycle as the change, to show that the sample is dropped. The bench then runs unbroken or gapped streams and drains the pipeline before the next change. Stream patterns include the full-scale extremes. These push the running sums to their bounds.

// File: rtl/tri_filt_pkg.sv
package tri_filt_pkg;
  parameter int DATA_W  = 14;
  parameter int EXP_W   = 4;
  parameter int MAX_EXP = 7;
  parameter int RNG_W   = 3;
  parameter int STAGES  = 2;

  localparam logic [RNG_W-1:0] RNG_WIDE   = 3'b100;
  localparam logic [RNG_W-1:0] RNG_MID    = 3'b010;
  localparam logic [RNG_W-1:0] RNG_NARROW = 3'b001;

  localparam int FLOOR_MID    = 2;
  localparam int FLOOR_NARROW = 4;
  localparam int RESET_EXP    = 2;
endpackage

// File: rtl/tri_filt_tapsel.sv
module tri_filt_tapsel
  import tri_filt_pkg::*;
#(
  parameter int EW   = EXP_W,
  parameter int MAXE = MAX_EXP
) (
  input  logic [EW-1:0]    exp_in,
  input  logic [RNG_W-1:0] rng,
  output logic [EW-1:0]    exp_eff
);
  always_comb begin
    exp_eff = exp_in;
    if (rng == RNG_MID && exp_eff < EW'(FLOOR_MID))
      exp_eff = EW'(FLOOR_MID);
    if (rng == RNG_NARROW && exp_eff < EW'(FLOOR_NARROW))
      exp_eff = EW'(FLOOR_NARROW);
    if (exp_eff > EW'(MAXE))
      exp_eff = EW'(MAXE);
  end
endmodule

// File: rtl/tri_filt_boxcar.sv
module tri_filt_boxcar
  import tri_filt_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int EW   = EXP_W,
  parameter int MAXE = MAX_EXP
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic [EW-1:0]        exp_sel,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_data
);
  localparam int DEPTH = 1 << MAXE;
  localparam int PTR_W = MAXE;
  localparam int CNT_W = MAXE + 1;
  localparam int SUM_W = DW + MAXE;

  logic signed [DW-1:0]    line_q [DEPTH];
  logic [PTR_W-1:0]        ptr_q;
  logic [CNT_W-1:0]        cnt_q;
  logic signed [SUM_W-1:0] sum_q;
  logic                    vld_q;

  logic [CNT_W-1:0]        taps;
  logic [PTR_W-1:0]        rd_ptr;
  logic                    full;
  logic signed [DW-1:0]    oldest;
  logic signed [SUM_W-1:0] sum_nxt;
  logic [CNT_W-1:0]        cnt_nxt;

  assign taps    = CNT_W'(1) << exp_sel;
  assign rd_ptr  = ptr_q - taps[PTR_W-1:0];
  assign full    = (cnt_q == taps);
  assign oldest  = full ? line_q[rd_ptr] : '0;
  assign sum_nxt = sum_q + SUM_W'(in_data) - SUM_W'(oldest);
  assign cnt_nxt = full ? cnt_q : cnt_q + CNT_W'(1);

  // delay line: no reset, single write port
  always_ff @(posedge clk) begin
    if (in_vld && !flush)
      line_q[ptr_q] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ptr_q <= '0;
      cnt_q <= '0;
      sum_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_vld && (cnt_nxt == taps);
      if (in_vld) begin
        ptr_q <= ptr_q + PTR_W'(1);
        cnt_q <= cnt_nxt;
        sum_q <= sum_nxt;
      end
    end
  end

  assign out_vld  = vld_q;
  assign out_data = DW'(sum_q >>> exp_sel);

  assert_vld_follows_in_R9: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(in_vld));

  assert_sum_hi_R1: assert property (@(posedge clk) disable iff (rst)
    int'(sum_q) <= ((1 << (DW-1)) - 1) * int'(taps));

  assert_sum_lo_R1: assert property (@(posedge clk) disable iff (rst)
    int'(sum_q) >= -(1 << (DW-1)) * int'(taps));
endmodule

// File: rtl/tri_avg_filter.sv
module tri_avg_filter
  import tri_filt_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int EW   = EXP_W,
  parameter int MAXE = MAX_EXP,
  parameter int NSTG = STAGES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_data,
  input  logic [EW-1:0]        tap_exp,
  input  logic [RNG_W-1:0]     range_sel,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_data
);
  logic [EW-1:0]    exp_eff;
  logic [EW-1:0]    exp_q;
  logic [RNG_W-1:0] rng_q;
  logic             flush;

  tri_filt_tapsel #(.EW(EW), .MAXE(MAXE)) u_tapsel (
    .exp_in (tap_exp),
    .rng    (range_sel),
    .exp_eff(exp_eff)
  );

  assign flush = (exp_eff != exp_q) || (range_sel != rng_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q <= EW'(RESET_EXP);
      rng_q <= RNG_WIDE;
    end else begin
      exp_q <= exp_eff;
      rng_q <= range_sel;
    end
  end

  logic                 chain_vld [NSTG+1];
  logic signed [DW-1:0] chain_dat [NSTG+1];

  assign chain_vld[0] = in_vld;
  assign chain_dat[0] = in_data;

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    tri_filt_boxcar #(.DW(DW), .EW(EW), .MAXE(MAXE)) u_box (
      .clk     (clk),
      .rst     (rst),
      .flush   (flush),
      .exp_sel (exp_q),
      .in_vld  (chain_vld[g]),
      .in_data (chain_dat[g]),
      .out_vld (chain_vld[g+1]),
      .out_data(chain_dat[g+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else if (exp_q == '0) begin
      out_vld  <= in_vld;
      if (in_vld) out_data <= in_data;
    end else begin
      out_vld  <= chain_vld[NSTG];
      if (chain_vld[NSTG]) out_data <= chain_dat[NSTG];
    end
  end

  assert_cap_R2: assert property (@(posedge clk) disable iff (rst)
    exp_eff <= EW'(MAXE));

  assert_floor_mid_R3: assert property (@(posedge clk) disable iff (rst)
    (range_sel == RNG_MID) |-> (exp_eff >= EW'(FLOOR_MID)));

  assert_floor_narrow_R3: assert property (@(posedge clk) disable iff (rst)
    (range_sel == RNG_NARROW) |-> (exp_eff >= EW'(FLOOR_NARROW)));

  assert_flush_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_vld);

  assert_bypass_R7: assert property (@(posedge clk) disable iff (rst)
    (!flush && exp_q == '0 && in_vld) |=> (out_vld && out_data == $past(in_data)));
endmodule

// File: tb/tri_avg_filter_tb_top.sv
module tri_avg_filter_tb_top;
  logic              clk = 1'b0;
  logic              rst;
  logic              in_vld;
  logic signed [13:0] in_data;
  logic [3:0]        tap_exp;
  logic [2:0]        range_sel;
  logic              out_vld;
  logic signed [13:0] out_data;

  always #10 clk = ~clk;

  tri_avg_filter dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
    .tap_exp(tap_exp), .range_sel(range_sel),
    .out_vld(out_vld), .out_data(out_data)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int obuf [512];
  int oc = 0;
  int ocyc = 0;
  bit capture = 0;

  always @(negedge clk) begin
    if (capture && out_vld) begin
      if (oc < 512) obuf[oc] = int'(out_data);
      oc = oc + 1;
      ocyc = cyc;
    end
  end

  int xs [512];
  int s1 [512];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int eff_exp(input int m, input logic [2:0] r);
    int e = m;
    if (r == 3'b010 && e < 2) e = 2;
    if (r == 3'b001 && e < 4) e = 4;
    if (e > 7) e = 7;
    return e;
  endfunction

  function automatic int gen(input int pat, input int i);
    case (pat)
      0: return ((i * 37) % 16384) - 8192;
      1: return (i % 2 == 0) ? 8191 : -8192;
      2: begin
        lfsr = {lfsr[14:0], 1'b0} ^ (lfsr[15] ? 16'h100B : 16'h0000);
        return int'($signed(lfsr[13:0]));
      end
      3: return -8192;
      default: return 8191;
    endcase
  endfunction

  task automatic run(input string tag, input int m, input logic [2:0] r,
                     input int pat, input bit gap, input bit drop);
    int e = eff_exp(m, r);
    int n = 1 << e;
    int len = (e == 0) ? 20 : 2*n - 2 + 20;
    int k = 0;
    int last_in = 0;
    int nexp = 0;
    int bad = 0;
    int first_bad_a = 0;
    int first_bad_e = 0;
    if (!drop) begin
      @(negedge clk);
      in_vld = 1'b0; tap_exp = 4'(m); range_sel = r;
      repeat (3) @(negedge clk);
    end
    oc = 0; capture = 1;
    if (drop) begin
      @(negedge clk);
      in_vld = 1'b1; in_data = 14'sd5000; tap_exp = 4'(m); range_sel = r;
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_vld = 1'b1;
      xs[k] = gen(pat, i);
      in_data = 14'(xs[k]);
      k++;
      last_in = cyc + 1;
      if (gap) begin
        @(negedge clk);
        in_vld = 1'b0;
      end
    end
    @(negedge clk);
    in_vld = 1'b0;
    repeat (6) @(negedge clk);
    @(posedge clk);
    capture = 0;
    if (e == 0) begin
      nexp = k;
      for (int j = 0; j < k; j++)
        if (bad == 0 && obuf[j] != xs[j]) begin
          bad++; first_bad_a = obuf[j]; first_bad_e = xs[j];
        end
    end else begin
      for (int j = n - 1; j < k; j++) begin
        int s = 0;
        for (int t = j - n + 1; t <= j; t++) s += xs[t];
        s1[j] = s >>> e;
      end
      nexp = k - (2*n - 2);
      for (int j = 2*n - 2; j < k; j++) begin
        int s = 0;
        int ex;
        for (int t = j - n + 1; t <= j; t++) s += s1[t];
        ex = s >>> e;
        if (bad == 0 && obuf[j - (2*n - 2)] != ex) begin
          bad++; first_bad_a = obuf[j - (2*n - 2)]; first_bad_e = ex;
        end
      end
    end
    chk("R5", $sformatf("output count M=%0d", e), oc, nexp);
    chk(tag, $sformatf("first mismatching value M=%0d", e), first_bad_a, first_bad_e);
    if (e == 0)
      chk("R7", "pass-through latency", ocyc - last_in, 0);
    else
      chk("R4", $sformatf("latency M=%0d", e), ocyc - last_in, 2);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_vld = 1'b0; in_data = '0; tap_exp = 4'd2; range_sel = 3'b100;
    repeat (3) @(negedge clk);
    chk("R8", "out_vld in reset", int'(out_vld), 0);
    chk("R8", "out_data in reset", int'(out_data), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8", "out_vld after reset", int'(out_vld), 0);

    run("R7", 0,  3'b100, 2, 0, 0);
    run("R1", 1,  3'b100, 0, 0, 0);
    run("R1", 2,  3'b100, 1, 0, 0);
    run("R9", 3,  3'b100, 2, 1, 0);
    run("R1", 5,  3'b100, 2, 0, 0);
    run("R1", 7,  3'b100, 1, 0, 0);
    run("R3", 0,  3'b010, 2, 0, 0);
    run("R3", 3,  3'b010, 0, 0, 0);
    run("R3", 1,  3'b001, 0, 0, 0);
    run("R3", 6,  3'b001, 3, 0, 0);
    run("R2", 12, 3'b100, 2, 0, 0);
    run("R6", 4,  3'b100, 2, 0, 1);
    run("R2", 15, 3'b001, 4, 0, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule